// File: doc/BRIEF.md
# Serial Flash Page Writer with Read-Back Check

This block copies a buffer of 32-bit words from a local memory into a serial NOR flash and proves each page by reading it back. One start pulse runs the whole job. The buffer is cut into pages, and the block handles each page in the same order. First it loads the page into a small internal RAM. Then it sends a write-enable frame, followed by a program frame that carries the address and the data. Next it polls the flash status until the write has finished. Last it reads the page back and compares every word against the RAM copy. The block counts the words that came back different. When the job ends it pulses done, and it raises an error flag if any word differed.

The flash side is a byte-level command port to an external SPI shifter. The block offers one byte at a time with a valid/ready handshake and marks the final byte of each chip-select frame. The shifter returns exactly one response byte for each byte it sends. The source side is a plain read port with one cycle of latency, so a block RAM fits it directly.

Top module: `pvf_flash_prog`

## Requirements
- R1: A start pulse taken while idle latches base address and word count, clears the mismatch count and drives busy high in the following cycle.
- R2: Every page program frame is preceded by its own one-byte frame carrying 0x06 with cmd_last high on that byte.
- R3: The program frame sends 0x02, three address bytes, then the page's source words in ascending index order, each as four bytes most significant first, with cmd_last only on the final data byte; source words are fetched by pulsing src_rd with src_addr and taking src_data one cycle later.
- R4: Pages hold PAGE_WORDS words, with the final page carrying only the remaining words. Page k uses flash address base + k*4*PAGE_WORDS. In both program and read frames this address is sent most significant byte first.
- R5: After each program frame the block sends two-byte frames 0x05, 0x00. It repeats them while bit 0 of the second response byte is 1. The read frame starts only after a poll has returned that bit as 0.
- R6: The read frame sends 0x03, the three address bytes and then 0x00 filler, four bytes per page word, with cmd_last on the last filler byte. The first four response bytes are discarded. The block packs the rest four to a word, most significant first, and compares each word with the word it programmed.
- R7: mismatch_cnt adds one for each read-back word that differs and holds at 2^CNT_W-1 once it gets there.
- R8: done is high for exactly one cycle, with busy low. In that cycle err equals (mismatch_cnt != 0), and err keeps its value until the next start. A word count of zero gives done with no command bytes and err low.
- R9: A byte offered on the command port keeps cmd_valid, cmd_byte and cmd_last steady until cmd_ready. No further byte is offered until the response to the previous one has arrived.
- R10: A start pulse while busy is ignored: it alters neither the command stream nor the results of the running job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (taken only when idle) |
| base_addr | input | 24 | Flash byte address of the first page |
| num_words | input | LEN_W | Number of 32-bit words to write |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | At least one word failed the read-back check |
| mismatch_cnt | output | CNT_W | Saturating count of mismatched words |
| src_rd | output | 1 | Source buffer read strobe |
| src_addr | output | LEN_W | Source buffer word index |
| src_data | input | 32 | Source word, valid the cycle after src_rd |
| cmd_valid | output | 1 | Command byte offered to the shifter |
| cmd_ready | input | 1 | Shifter accepts the byte |
| cmd_byte | output | 8 | Byte to shift out |
| cmd_last | output | 1 | Byte closes the chip-select frame |
| rsp_valid | input | 1 | Response byte for the last accepted byte |
| rsp_byte | input | 8 | Byte shifted in during that transfer |

## Verification
The bench's shifter model returns each response two cycles after the accepted handshake. The block offers its next byte no sooner than one cycle after that response arrives, so the bench checks the command stream at the handshakes, in order, rather than at fixed cycles. done is due two cycles after the final read-back response is taken, and busy is due one cycle after start. The bench therefore samples status on falling edges: it checks busy right after the start edge, waits for done, and checks mismatch_cnt and err in the done cycle. It then checks that done has dropped one cycle later. The expected mismatch counts come from corruptions that the flash model injects at chosen byte addresses.

// File: rtl/pvf_pkg.sv
package pvf_pkg;

  localparam int FA_W = 24;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] FILLER  = 8'h00;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_WREN,
    S_PROG,
    S_POLL,
    S_READ,
    S_NEXT,
    S_FIN
  } pvf_state_t;

endpackage

// File: rtl/pvf_page_buf.sv
module pvf_page_buf #(
  parameter int WORDS = 64,
  parameter int DW    = 32,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/pvf_sat_cnt.sv
module pvf_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (inc && (q != TOP)) begin
      q <= q + W'(1);
    end
  end

endmodule

// File: rtl/pvf_flash_prog.sv
module pvf_flash_prog
  import pvf_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int PAGE_WORDS = 64,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FA_W-1:0]   base_addr,
  input  logic [LEN_W-1:0]  num_words,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CNT_W-1:0]  mismatch_cnt,
  output logic              src_rd,
  output logic [LEN_W-1:0]  src_addr,
  input  logic [31:0]       src_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_byte,
  output logic              cmd_last,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_byte
);

  localparam int AW   = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam int BI_W = $clog2(4 * PAGE_WORDS + 5);
  localparam logic [FA_W-1:0]  PAGE_BYTES = FA_W'(4 * PAGE_WORDS);
  localparam logic [LEN_W-1:0] PW_MAX     = LEN_W'(PAGE_WORDS);

  pvf_state_t st;

  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] sidx;
  logic [LEN_W-1:0] lidx;
  logic [LEN_W-1:0] iss_loc;
  logic [LEN_W-1:0] wr_loc;
  logic [LEN_W-1:0] pw;
  logic             ld_v;
  logic [FA_W-1:0]  faddr;
  logic [BI_W-1:0]  bidx;
  logic [BI_W-1:0]  flen;
  logic [BI_W-1:0]  boff;
  logic             wait_rsp;
  logic             gap;
  logic             in_frame;
  logic             last_b;
  logic             rsp_take;
  logic [23:0]      rx_sh;
  logic [31:0]      buf_q;
  logic [31:0]      rx_word;
  logic [7:0]       byte_c;
  logic [7:0]       data_b;
  logic [AW-1:0]    buf_wa;
  logic [AW-1:0]    buf_ra;
  logic             cnt_clr;
  logic             cnt_inc;

  // words in the current page
  assign pw = (rem >= PW_MAX) ? PW_MAX : rem;

  assign in_frame = (st == S_WREN) || (st == S_PROG) ||
                    (st == S_POLL) || (st == S_READ);

  always_comb begin
    unique case (st)
      S_WREN:  flen = BI_W'(1);
      S_POLL:  flen = BI_W'(2);
      default: flen = (BI_W'(pw) << 2) + BI_W'(4);
    endcase
  end

  assign last_b   = (bidx == flen - BI_W'(1));
  assign boff     = bidx - BI_W'(4);
  assign rsp_take = rsp_valid && wait_rsp;

  // page buffer: filled from the source, read for program and compare
  assign buf_wa = AW'(wr_loc);
  assign buf_ra = AW'(boff >> 2);

  pvf_page_buf #(
    .WORDS (PAGE_WORDS),
    .DW    (32),
    .AW    (AW)
  ) u_buf (
    .clk     (clk),
    .wr_en   (ld_v),
    .wr_addr (buf_wa),
    .wr_data (src_data),
    .rd_addr (buf_ra),
    .rd_q    (buf_q)
  );

  always_comb begin
    unique case (bidx[1:0])
      2'd0:    data_b = buf_q[31:24];
      2'd1:    data_b = buf_q[23:16];
      2'd2:    data_b = buf_q[15:8];
      default: data_b = buf_q[7:0];
    endcase
  end

  always_comb begin
    byte_c = FILLER;
    unique case (st)
      S_WREN: byte_c = OP_WREN;
      S_POLL: byte_c = (bidx == '0) ? OP_RDSR : FILLER;
      S_PROG, S_READ: begin
        if (bidx == BI_W'(0))      byte_c = (st == S_PROG) ? OP_PROG : OP_READ;
        else if (bidx == BI_W'(1)) byte_c = faddr[23:16];
        else if (bidx == BI_W'(2)) byte_c = faddr[15:8];
        else if (bidx == BI_W'(3)) byte_c = faddr[7:0];
        else                       byte_c = (st == S_PROG) ? data_b : FILLER;
      end
      default: byte_c = FILLER;
    endcase
  end

  assign cmd_valid = in_frame && !wait_rsp && !gap;
  assign cmd_byte  = byte_c;
  assign cmd_last  = in_frame && last_b;

  // read-back compare
  assign rx_word = {rx_sh, rsp_byte};
  assign cnt_clr = (st == S_IDLE) && start;
  assign cnt_inc = (st == S_READ) && rsp_take && (bidx > BI_W'(3)) &&
                   (bidx[1:0] == 2'b11) && (rx_word != buf_q);

  pvf_sat_cnt #(
    .W (CNT_W)
  ) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .q   (mismatch_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      src_rd   <= 1'b0;
      src_addr <= '0;
      rem      <= '0;
      sidx     <= '0;
      lidx     <= '0;
      iss_loc  <= '0;
      wr_loc   <= '0;
      ld_v     <= 1'b0;
      faddr    <= '0;
      bidx     <= '0;
      wait_rsp <= 1'b0;
      gap      <= 1'b0;
      rx_sh    <= '0;
    end else begin
      done   <= 1'b0;
      src_rd <= 1'b0;
      gap    <= 1'b0;
      ld_v   <= src_rd;
      wr_loc <= iss_loc;

      if (cmd_valid && cmd_ready) begin
        wait_rsp <= 1'b1;
      end

      unique case (st)
        S_IDLE: begin
          if (start) begin
            rem   <= num_words;
            sidx  <= '0;
            lidx  <= '0;
            faddr <= base_addr;
            err   <= 1'b0;
            busy  <= 1'b1;
            st    <= (num_words == '0) ? S_FIN : S_LOAD;
          end
        end

        S_LOAD: begin
          if (lidx < pw) begin
            src_rd   <= 1'b1;
            src_addr <= sidx + lidx;
            iss_loc  <= lidx;
            lidx     <= lidx + LEN_W'(1);
          end else if (!src_rd && !ld_v) begin
            bidx <= '0;
            st   <= S_WREN;
          end
        end

        S_WREN, S_PROG, S_POLL, S_READ: begin
          if (rsp_take) begin
            wait_rsp <= 1'b0;
            gap      <= 1'b1;
            if (st == S_READ) begin
              rx_sh <= rx_word[23:0];
            end
            if (last_b) begin
              bidx <= '0;
              unique case (st)
                S_WREN:  st <= S_PROG;
                S_PROG:  st <= S_POLL;
                S_POLL:  st <= rsp_byte[0] ? S_POLL : S_READ;
                default: st <= S_NEXT;
              endcase
            end else begin
              bidx <= bidx + BI_W'(1);
            end
          end
        end

        S_NEXT: begin
          rem   <= rem - pw;
          sidx  <= sidx + pw;
          faddr <= faddr + PAGE_BYTES;
          lidx  <= '0;
          st    <= (rem == pw) ? S_FIN : S_LOAD;
        end

        S_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          err  <= (mismatch_cnt != '0);
          st   <= S_IDLE;
        end

        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pvf_chk.sv
module pvf_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [CNT_W-1:0] mismatch_cnt,
  input logic             src_rd,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [7:0]       cmd_byte,
  input logic             cmd_last,
  input logic             rsp_valid
);

  logic outstanding;
  logic frame_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
      frame_open  <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        outstanding <= 1'b1;
        frame_open  <= !cmd_last;
      end else if (rsp_valid) begin
        outstanding <= 1'b0;
      end
    end
  end

  // R9
  hold_offer_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte) && $stable(cmd_last)));

  // R9
  one_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !outstanding);

  // R2
  frame_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !frame_open) |->
      (cmd_byte == 8'h06 || cmd_byte == 8'h02 || cmd_byte == 8'h05 || cmd_byte == 8'h03));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && (err == (mismatch_cnt != '0))));

  // R7
  count_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (mismatch_cnt >= $past(mismatch_cnt)));

  // R3
  src_busy_chk: assert property (@(posedge clk) disable iff (rst)
    src_rd |-> busy);

endmodule

bind pvf_flash_prog pvf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .mismatch_cnt (mismatch_cnt),
  .src_rd       (src_rd),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_byte     (cmd_byte),
  .cmd_last     (cmd_last),
  .rsp_valid    (rsp_valid)
);

// File: tb/sim_pvf_flash_prog.sv
`timescale 1ns/1ps
module sim_pvf_flash_prog;

  localparam int LEN_W = 8;
  localparam int PW    = 4;
  localparam int CNT_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [23:0]      base_addr = '0;
  logic [LEN_W-1:0] num_words = '0;
  logic             busy, done, err;
  logic [CNT_W-1:0] mismatch_cnt;
  logic             src_rd;
  logic [LEN_W-1:0] src_addr;
  logic [31:0]      src_data;
  logic             cmd_valid, cmd_ready, cmd_last;
  logic [7:0]       cmd_byte;
  logic             rsp_valid;
  logic [7:0]       rsp_byte;

  always #2 clk = ~clk;

  pvf_flash_prog #(.LEN_W(LEN_W), .PAGE_WORDS(PW), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .num_words(num_words),
    .busy(busy), .done(done), .err(err), .mismatch_cnt(mismatch_cnt),
    .src_rd(src_rd), .src_addr(src_addr), .src_data(src_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
  );

  int checks = 0;
  int errs   = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // scoreboard of expected command bytes {last, byte}
  logic [8:0] exp_q[$];
  string      tag_q[$];

  task automatic push(input logic [7:0] b, input bit l, input string t);
    exp_q.push_back({l, b});
    tag_q.push_back(t);
  endtask

  function automatic logic [31:0] pat(input logic [7:0] seed, input int i);
    logic [7:0] x;
    x = 8'(i);
    return {seed, x, ~x, seed ^ x};
  endfunction

  // source buffer, one cycle read latency
  logic [31:0] src_mem [256];
  always @(posedge clk) begin
    if (src_rd) src_data <= src_mem[src_addr];
  end

  // shifter + flash model
  logic [7:0]  fmem [256];
  bit          bad  [256];
  bit          all_bad = 1'b0;
  int          wip_polls = 0;
  int          wip_cnt, pos, rc, idx;
  logic [7:0]  op, o, rb;
  logic [23:0] fa;
  logic        wel, p1_v;
  logic [7:0]  p1_b;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) fmem[i] <= 8'hFF;
      pos <= 0; rc <= 0; wip_cnt <= 0; op <= 8'h00; fa <= '0; wel <= 1'b0;
      p1_v <= 1'b0; p1_b <= 8'h00; rsp_valid <= 1'b0; rsp_byte <= 8'h00; cmd_ready <= 1'b0;
    end else begin
      rsp_valid <= p1_v;
      rsp_byte  <= p1_b;
      p1_v      <= 1'b0;
      rc        <= rc + 1;
      cmd_ready <= (rc % 3) != 2;
      if (cmd_valid && cmd_ready) begin
        o   = (pos == 0) ? cmd_byte : op;
        idx = (int'(fa) + pos - 4) & 255;
        rb  = 8'hA5;
        if (o == 8'h03 && pos >= 4) rb = fmem[idx] ^ ((bad[idx] || all_bad) ? 8'h01 : 8'h00);
        if (o == 8'h05 && pos == 1) rb = {7'd0, wip_cnt != 0};
        p1_v <= 1'b1;
        p1_b <= rb;
        if (pos == 0) op <= cmd_byte;
        if (pos >= 1 && pos <= 3 && (o == 8'h02 || o == 8'h03)) fa <= {fa[15:0], cmd_byte};
        if (o == 8'h02 && pos >= 4 && wel) fmem[idx] <= fmem[idx] & cmd_byte;
        if (cmd_last) begin
          pos <= 0;
          if (o == 8'h06) wel <= 1'b1;
          if (o == 8'h02) begin wel <= 1'b0; wip_cnt <= wip_polls; end
          if (o == 8'h05 && wip_cnt > 0) wip_cnt <= wip_cnt - 1;
        end else begin
          pos <= pos + 1;
        end
      end
    end
  end

  // monitor: compare each accepted byte with the scoreboard
  logic [8:0] m_e;
  string      m_t;
  always @(posedge clk) begin
    if (!rst && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected command byte", {23'd0, cmd_last, cmd_byte}, 32'h0);
      end else begin
        m_e = exp_q.pop_front();
        m_t = tag_q.pop_front();
        chk({cmd_last, cmd_byte} == m_e, m_t, "command byte {last,byte}",
            {23'd0, cmd_last, cmd_byte}, {23'd0, m_e});
      end
    end
  end

  task automatic run(input logic [23:0] base, input int n, input int polls,
                     input logic [7:0] seed, input bit poke);
    int pages, k, exp_mm, cyc;
    logic [23:0] a;
    logic [31:0] d;
    bit wbad;
    exp_mm = 0;
    wip_polls = polls;
    for (int i = 0; i < n; i++) src_mem[i] = pat(seed, i);
    pages = (n + PW - 1) / PW;
    for (int p = 0; p < pages; p++) begin
      k = (n - p * PW > PW) ? PW : n - p * PW;
      a = base + 24'(p * 4 * PW);
      push(8'h06, 1'b1, "R2");
      push(8'h02, 1'b0, "R3");
      push(a[23:16], 1'b0, "R4"); push(a[15:8], 1'b0, "R4"); push(a[7:0], 1'b0, "R4");
      for (int w = 0; w < k; w++) begin
        d = pat(seed, p * PW + w);
        for (int b = 0; b < 4; b++) push(d[31 - 8 * b -: 8], (w == k - 1) && (b == 3), "R3");
      end
      for (int j = 0; j <= polls; j++) begin
        push(8'h05, 1'b0, "R5"); push(8'h00, 1'b1, "R5");
      end
      push(8'h03, 1'b0, "R6");
      push(a[23:16], 1'b0, "R4"); push(a[15:8], 1'b0, "R4"); push(a[7:0], 1'b0, "R4");
      for (int i = 0; i < 4 * k; i++) push(8'h00, i == 4 * k - 1, "R6");
      for (int w = 0; w < k; w++) begin
        wbad = all_bad;
        for (int b = 0; b < 4; b++) if (bad[(int'(a) + 4 * w + b) & 255]) wbad = 1'b1;
        if (wbad) exp_mm++;
      end
    end
    if (exp_mm > 7) exp_mm = 7;

    @(negedge clk);
    base_addr = base; num_words = LEN_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", "busy after start", {31'd0, busy}, 32'd1);
    if (poke) begin
      repeat (20) @(negedge clk);
      base_addr = 24'h0000F0; num_words = LEN_W'(1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10", "busy kept over ignored start", {31'd0, busy}, 32'd1);
    end
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 5000, "R8", "watchdog waiting for done", cyc, 32'd5000);
    chk(busy == 1'b0, "R8", "busy low with done", {31'd0, busy}, 32'd0);
    chk(mismatch_cnt == CNT_W'(exp_mm), "R7", "mismatch count", {29'd0, mismatch_cnt}, exp_mm);
    chk(err == (exp_mm != 0), "R8", "error flag with done", {31'd0, err}, {31'd0, exp_mm != 0});
    chk(exp_q.size() == 0, "R6", "bytes still expected", exp_q.size(), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done lasts one cycle", {31'd0, done}, 32'd0);
    chk(err == (exp_mm != 0), "R8", "error flag held", {31'd0, err}, {31'd0, exp_mm != 0});
    exp_q.delete();
    tag_q.delete();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bad[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "reset busy", {31'd0, busy}, 32'd0);
    chk(done == 1'b0, "R8", "reset done", {31'd0, done}, 32'd0);
    chk(err == 1'b0, "R8", "reset err", {31'd0, err}, 32'd0);
    chk(mismatch_cnt == '0, "R7", "reset count", {29'd0, mismatch_cnt}, 32'd0);
    chk(cmd_valid == 1'b0, "R9", "reset cmd_valid", {31'd0, cmd_valid}, 32'd0);
    chk(src_rd == 1'b0, "R3", "reset src_rd", {31'd0, src_rd}, 32'd0);

    // single full page, status clear at first poll
    run(24'h000000, 4, 0, 8'h11, 1'b0);
    // three pages with a short last page, busy polls, ignored restart
    run(24'h000020, 10, 2, 8'h22, 1'b1);
    // two corrupted words in one page
    bad[8'h85] = 1'b1;
    bad[8'h8E] = 1'b1;
    run(24'h000080, 4, 1, 8'h33, 1'b0);
    bad[8'h85] = 1'b0;
    bad[8'h8E] = 1'b0;
    // every word corrupted: count saturates at 7
    all_bad = 1'b1;
    run(24'h0000A0, 9, 0, 8'h44, 1'b0);
    all_bad = 1'b0;
    // zero length after a failing job: count cleared, no traffic
    run(24'h000000, 0, 0, 8'h55, 1'b0);
    chk(mismatch_cnt == '0, "R1", "count cleared by start", {29'd0, mismatch_cnt}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #400000;
    chk(1'b0, "R8", "global watchdog", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule